// File: doc/BRIEF.md
# Processor port resource decoder

This block is the port logic that sits between a controlling processor and a bidirectional FIFO pair. The processor presents a chip select, a three-bit address, a read/write strobe, a port enable, an output enable and an 18-bit write word. The block turns these into one of six resource accesses. Two are data resources: the FIFO data path, which pushes toward the far side and pops from the near-side FIFO, and the bypass path. Four are per-direction threshold-offset registers, holding the almost-empty and almost-full offsets for the forward and the reverse FIFO.

The offset registers live inside the block and feed the flag logic of the two FIFOs. The FIFO storage and the bypass flag synchroniser are outside it. The block only issues strobes, forwards the write word, and selects the read word from the FIFO output register, the bypass register or an offset register. It also decodes the device reset condition from the reset pin combined with the chip select and both port enables. When that condition is decoded, all four offsets return to their default at the next clock edge.

Top module: `ctl_port_decode`

## Requirements
- R1: While `cs_n` is 1, or while `a_en_n` is 1, no strobe (`fifo_push`, `fifo_pop`, `byp_wr`, `byp_rd`) is raised and no offset register changes. While `cs_n` is 1, `bus_oe` is 0 and `rd_data` is 0.
- R2: With `cs_n`=0, `a_en_n`=0 and address 3'b000, `rd_wr`=0 raises `fifo_push` in the same cycle with `out_data` equal to `wr_data`. `rd_wr`=1 raises `fifo_pop` and returns `fifo_rdata` on `rd_data`.
- R3: Address 3'b001 uses the bypass path instead: `byp_wr` on a write, `byp_rd` on a read with `rd_data` equal to `byp_rdata`. No FIFO strobe is raised.
- R4: An enabled write (`rd_wr`=0) with `addr[2]`=1 loads `wr_data[OFS_W-1:0]` into one offset register at the next clock edge. `addr[1:0]` selects it: 00 forward almost-empty, 01 forward almost-full, 10 reverse almost-empty, 11 reverse almost-full. The other three registers hold.
- R5: A read (`rd_wr`=1, `cs_n`=0) with `addr[2]`=1 returns the selected offset in `rd_data[OFS_W-1:0]`, with the upper bits 0. During any write, `rd_data` is 0.
- R6: Addresses 3'b010 and 3'b011 are reserved. A write to them changes no offset and raises no strobe, and a read returns 0.
- R7: `bus_oe` is 1 exactly when `cs_n`=0, `oe_n`=0 and `rd_wr`=1.
- R8: `port_rst` is 1 exactly when `rst_in_n`=0 while `cs_n`, `a_en_n` and `b_en_n` are all 1. At the clock edge where `port_rst` is 1, all four offsets load `RST_VAL` (default 8).
- R9: `rst_in_n`=0 with any of `cs_n`, `a_en_n` or `b_en_n` at 0 is not a reset. Offsets hold, and an enabled offset write in that cycle takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_in_n | input | 1 | Raw reset pin, active low, qualified inside |
| cs_n | input | 1 | Chip select, active low |
| addr | input | 3 | Resource address |
| rd_wr | input | 1 | 1 = read, 0 = write |
| a_en_n | input | 1 | Controlling-port enable, active low |
| b_en_n | input | 1 | Far-port enable, active low (reset qualification only) |
| oe_n | input | 1 | Output enable request, active low |
| wr_data | input | DATA_W | Write word from the processor |
| fifo_rdata | input | DATA_W | Incoming FIFO output register |
| byp_rdata | input | DATA_W | Bypass register toward this port |
| out_data | output | DATA_W | Write word forwarded to FIFO and bypass |
| fifo_push | output | 1 | Push strobe to the outgoing FIFO |
| fifo_pop | output | 1 | Pop strobe to the incoming FIFO |
| byp_wr | output | 1 | Bypass write strobe |
| byp_rd | output | 1 | Bypass read strobe |
| rd_data | output | DATA_W | Selected read word |
| bus_oe | output | 1 | Data bus drive enable (0 = high impedance) |
| port_rst | output | 1 | Decoded device reset |
| ofs_ae_fwd | output | OFS_W | Forward almost-empty offset |
| ofs_af_fwd | output | OFS_W | Forward almost-full offset |
| ofs_ae_rev | output | OFS_W | Reverse almost-empty offset |
| ofs_af_rev | output | OFS_W | Reverse almost-full offset |

## Verification
The reset pin and an offset write can fall in the same cycle, because the reset pin is not masked by the access controls. The bench provokes this by pulling `rst_in_n` low while an enabled write to the forward almost-full offset is on the bus. It then reads the register back after the edge and expects the written value, not the default, and it expects `port_rst` to stay 0 in that cycle. A second case lowers only `b_en_n` during a reset pulse and expects every offset to hold. A full reset afterwards must restore the defaults.

// File: rtl/ctl_port_pkg.sv
package ctl_port_pkg;

   localparam int NUM_THR = 4;

   // threshold slot order is decoded from addr[1:0]
   localparam int THR_AE_FWD = 0;
   localparam int THR_AF_FWD = 1;
   localparam int THR_AE_REV = 2;
   localparam int THR_AF_REV = 3;

   typedef struct packed {
      logic               fifo;
      logic               byp;
      logic               rsvd;
      logic [NUM_THR-1:0] thr;
   } port_sel_t;

endpackage

// File: rtl/ctl_port_addr_dec.sv
module ctl_port_addr_dec
   import ctl_port_pkg::*;
(
   input  logic      cs_n,
   input  logic [2:0] addr,
   output port_sel_t sel
);

   always_comb begin
      sel = '0;
      if (!cs_n) begin
         if (addr[2]) begin
            sel.thr[addr[1:0]] = 1'b1;
         end else if (addr[1]) begin
            sel.rsvd = 1'b1;
         end else if (addr[0]) begin
            sel.byp = 1'b1;
         end else begin
            sel.fifo = 1'b1;
         end
      end
   end

endmodule

// File: rtl/ctl_port_thr_bank.sv
module ctl_port_thr_bank #(
   parameter int N       = 4,
   parameter int OFS_W   = 8,
   parameter int RST_VAL = 8
) (
   input  logic                      clk,
   input  logic                      load_rst,
   input  logic [N-1:0]              wr_en,
   input  logic [OFS_W-1:0]          wr_val,
   output logic [N-1:0][OFS_W-1:0]   ofs_q
);

   localparam logic [OFS_W-1:0] RST_OFS = OFS_W'(RST_VAL);

   for (genvar i = 0; i < N; i++) begin : g_slot
      logic [OFS_W-1:0] slot_q;

      always_ff @(posedge clk) begin
         if (load_rst) begin
            slot_q <= RST_OFS;
         end else if (wr_en[i]) begin
            slot_q <= wr_val;
         end
      end

      assign ofs_q[i] = slot_q;
   end

endmodule

// File: rtl/ctl_port_rd_mux.sv
module ctl_port_rd_mux
   import ctl_port_pkg::*;
#(
   parameter int DATA_W = 18,
   parameter int OFS_W  = 8
) (
   input  port_sel_t                    sel,
   input  logic                         rd_wr,
   input  logic [DATA_W-1:0]            fifo_rdata,
   input  logic [DATA_W-1:0]            byp_rdata,
   input  logic [NUM_THR-1:0][OFS_W-1:0] ofs,
   output logic [DATA_W-1:0]            rdata
);

   always_comb begin
      rdata = '0;
      if (rd_wr) begin
         if (sel.fifo) rdata = fifo_rdata;
         if (sel.byp)  rdata = byp_rdata;
         for (int k = 0; k < NUM_THR; k++) begin
            if (sel.thr[k]) rdata[OFS_W-1:0] = ofs[k];
         end
      end
   end

endmodule

// File: rtl/ctl_port_decode.sv
module ctl_port_decode
   import ctl_port_pkg::*;
#(
   parameter int DATA_W  = 18,
   parameter int OFS_W   = 8,
   parameter int RST_VAL = 8,
   parameter bit RD_REG  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_in_n,
   input  logic              cs_n,
   input  logic [2:0]        addr,
   input  logic              rd_wr,
   input  logic              a_en_n,
   input  logic              b_en_n,
   input  logic              oe_n,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [DATA_W-1:0] fifo_rdata,
   input  logic [DATA_W-1:0] byp_rdata,
   output logic [DATA_W-1:0] out_data,
   output logic              fifo_push,
   output logic              fifo_pop,
   output logic              byp_wr,
   output logic              byp_rd,
   output logic [DATA_W-1:0] rd_data,
   output logic              bus_oe,
   output logic              port_rst,
   output logic [OFS_W-1:0]  ofs_ae_fwd,
   output logic [OFS_W-1:0]  ofs_af_fwd,
   output logic [OFS_W-1:0]  ofs_ae_rev,
   output logic [OFS_W-1:0]  ofs_af_rev
);

   initial begin
      if (OFS_W < 1 || OFS_W > DATA_W)
         $error("ctl_port_decode: OFS_W must lie in 1..DATA_W");
      if (RST_VAL < 0 || RST_VAL >= (1 << OFS_W))
         $error("ctl_port_decode: RST_VAL does not fit in OFS_W bits");
   end

   port_sel_t                     sel;
   logic                          access;
   logic                          wr_go;
   logic                          rd_go;
   logic [NUM_THR-1:0]            thr_we;
   logic [NUM_THR-1:0][OFS_W-1:0] ofs;
   logic [DATA_W-1:0]             rd_mux;

   // device reset is qualified by an idle port on both sides
   assign port_rst = !rst_in_n && cs_n && a_en_n && b_en_n;

   assign access = !cs_n && !a_en_n;
   assign wr_go  = access && !rd_wr;
   assign rd_go  = access &&  rd_wr;

   ctl_port_addr_dec u_dec (
      .cs_n (cs_n),
      .addr (addr),
      .sel  (sel)
   );

   assign fifo_push = wr_go && sel.fifo;
   assign fifo_pop  = rd_go && sel.fifo;
   assign byp_wr    = wr_go && sel.byp;
   assign byp_rd    = rd_go && sel.byp;
   assign thr_we    = {NUM_THR{wr_go}} & sel.thr;
   assign out_data  = wr_data;
   assign bus_oe    = !cs_n && !oe_n && rd_wr;

   ctl_port_thr_bank #(
      .N       (NUM_THR),
      .OFS_W   (OFS_W),
      .RST_VAL (RST_VAL)
   ) u_thr (
      .clk      (clk),
      .load_rst (port_rst),
      .wr_en    (thr_we),
      .wr_val   (wr_data[OFS_W-1:0]),
      .ofs_q    (ofs)
   );

   assign ofs_ae_fwd = ofs[THR_AE_FWD];
   assign ofs_af_fwd = ofs[THR_AF_FWD];
   assign ofs_ae_rev = ofs[THR_AE_REV];
   assign ofs_af_rev = ofs[THR_AF_REV];

   ctl_port_rd_mux #(
      .DATA_W (DATA_W),
      .OFS_W  (OFS_W)
   ) u_rmux (
      .sel        (sel),
      .rd_wr      (rd_wr),
      .fifo_rdata (fifo_rdata),
      .byp_rdata  (byp_rdata),
      .ofs        (ofs),
      .rdata      (rd_mux)
   );

   if (RD_REG) begin : g_rd_flop
      logic [DATA_W-1:0] rd_q;
      always_ff @(posedge clk) begin
         rd_q <= rd_mux;
      end
      assign rd_data = rd_q;
   end else begin : g_rd_comb
      assign rd_data = rd_mux;
   end

endmodule

// File: rtl/ctl_port_decode_chk.sv
module ctl_port_decode_chk #(
   parameter int DATA_W  = 18,
   parameter int OFS_W   = 8,
   parameter int RST_VAL = 8,
   parameter bit RD_REG  = 1'b0
) (
   input logic              clk,
   input logic              rst_in_n,
   input logic              cs_n,
   input logic [2:0]        addr,
   input logic              rd_wr,
   input logic              a_en_n,
   input logic [DATA_W-1:0] wr_data,
   input logic              fifo_push,
   input logic              fifo_pop,
   input logic              byp_wr,
   input logic              byp_rd,
   input logic [DATA_W-1:0] rd_data,
   input logic              bus_oe,
   input logic              port_rst,
   input logic [OFS_W-1:0]  ofs_ae_fwd,
   input logic [OFS_W-1:0]  ofs_af_fwd,
   input logic [OFS_W-1:0]  ofs_ae_rev,
   input logic [OFS_W-1:0]  ofs_af_rev
);

   localparam logic [OFS_W-1:0] RST_OFS = OFS_W'(RST_VAL);

   // offsets are undefined until the first decoded reset
   logic armed = 1'b0;
   always_ff @(posedge clk) begin
      if (port_rst) armed <= 1'b1;
   end

   logic wr_en_cyc;
   assign wr_en_cyc = !cs_n && !a_en_n && !rd_wr;

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!armed)
      cs_n |-> !(fifo_push || fifo_pop || byp_wr || byp_rd || bus_oe));

   a_r2_single_strobe: assert property (@(posedge clk) disable iff (!armed)
      $onehot0({fifo_push, fifo_pop, byp_wr, byp_rd}));

   a_r4_fwd_ae_load: assert property (@(posedge clk) disable iff (!armed)
      (wr_en_cyc && addr == 3'b100) |=> ofs_ae_fwd == $past(wr_data[OFS_W-1:0]));

   a_r4_rev_ae_load: assert property (@(posedge clk) disable iff (!armed)
      (wr_en_cyc && addr == 3'b110) |=> ofs_ae_rev == $past(wr_data[OFS_W-1:0]));

   a_r6_rsvd_hold: assert property (@(posedge clk) disable iff (!armed)
      (!cs_n && addr[2:1] == 2'b01)
      |=> $stable({ofs_ae_fwd, ofs_af_fwd, ofs_ae_rev, ofs_af_rev}));

   a_r6_rsvd_zero: assert property (@(posedge clk) disable iff (!armed)
      (!RD_REG && !cs_n && rd_wr && addr[2:1] == 2'b01) |-> rd_data == '0);

   a_r8_reset_load: assert property (@(posedge clk) disable iff (!armed)
      port_rst |=> (ofs_ae_fwd == RST_OFS && ofs_af_fwd == RST_OFS &&
                    ofs_ae_rev == RST_OFS && ofs_af_rev == RST_OFS));

   a_r9_write_beats_pin: assert property (@(posedge clk) disable iff (!armed)
      (!rst_in_n && wr_en_cyc && addr == 3'b101)
      |=> ofs_af_fwd == $past(wr_data[OFS_W-1:0]));

endmodule

bind ctl_port_decode ctl_port_decode_chk #(
   .DATA_W  (DATA_W),
   .OFS_W   (OFS_W),
   .RST_VAL (RST_VAL),
   .RD_REG  (RD_REG)
) u_chk (.*);

// File: tb/test_ctl_port_decode.sv
module test_ctl_port_decode;

   localparam int DATA_W = 18;
   localparam int OFS_W  = 8;
   localparam logic [17:0] FIFO_WORD = 18'h1A5A5;
   localparam logic [17:0] BYP_WORD  = 18'h2C3C3;

   logic              clk = 1'b0;
   logic              rst_in_n = 1'b1;
   logic              cs_n = 1'b1;
   logic [2:0]        addr = 3'b000;
   logic              rd_wr = 1'b1;
   logic              a_en_n = 1'b1;
   logic              b_en_n = 1'b1;
   logic              oe_n = 1'b1;
   logic [DATA_W-1:0] wr_data = '0;
   logic [DATA_W-1:0] fifo_rdata = FIFO_WORD;
   logic [DATA_W-1:0] byp_rdata = BYP_WORD;
   logic [DATA_W-1:0] out_data;
   logic              fifo_push, fifo_pop, byp_wr, byp_rd;
   logic [DATA_W-1:0] rd_data;
   logic              bus_oe, port_rst;
   logic [OFS_W-1:0]  ofs_ae_fwd, ofs_af_fwd, ofs_ae_rev, ofs_af_rev;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   ctl_port_decode i_ctl_port_decode (
      .clk (clk), .rst_in_n (rst_in_n), .cs_n (cs_n), .addr (addr),
      .rd_wr (rd_wr), .a_en_n (a_en_n), .b_en_n (b_en_n), .oe_n (oe_n),
      .wr_data (wr_data), .fifo_rdata (fifo_rdata), .byp_rdata (byp_rdata),
      .out_data (out_data), .fifo_push (fifo_push), .fifo_pop (fifo_pop),
      .byp_wr (byp_wr), .byp_rd (byp_rd), .rd_data (rd_data),
      .bus_oe (bus_oe), .port_rst (port_rst),
      .ofs_ae_fwd (ofs_ae_fwd), .ofs_af_fwd (ofs_af_fwd),
      .ofs_ae_rev (ofs_ae_rev), .ofs_af_rev (ofs_af_rev)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // vector: cs_n, a_en_n, rd_wr, oe_n, addr, wr_data | push,pop,bwr,brd, oe, rd_data
   localparam int NV = 21;
   localparam logic [47:0] VEC [NV] = '{
      {1'b1,1'b0,1'b0,1'b0,3'b000,18'h00011, 4'b0000,1'b0,18'h00000},
      {1'b0,1'b0,1'b0,1'b0,3'b000,18'h01234, 4'b1000,1'b0,18'h00000},
      {1'b0,1'b0,1'b1,1'b0,3'b000,18'h00000, 4'b0100,1'b1,18'h1A5A5},
      {1'b0,1'b0,1'b1,1'b1,3'b000,18'h00000, 4'b0100,1'b0,18'h1A5A5},
      {1'b0,1'b0,1'b0,1'b0,3'b001,18'h00055, 4'b0010,1'b0,18'h00000},
      {1'b0,1'b0,1'b1,1'b0,3'b001,18'h00000, 4'b0001,1'b1,18'h2C3C3},
      {1'b0,1'b0,1'b0,1'b0,3'b100,18'h00003, 4'b0000,1'b0,18'h00000},
      {1'b0,1'b0,1'b0,1'b0,3'b101,18'h001F0, 4'b0000,1'b0,18'h00000},
      {1'b0,1'b0,1'b0,1'b0,3'b110,18'h00021, 4'b0000,1'b0,18'h00000},
      {1'b0,1'b0,1'b0,1'b0,3'b111,18'h3FE77, 4'b0000,1'b0,18'h00000},
      {1'b0,1'b0,1'b1,1'b0,3'b100,18'h00000, 4'b0000,1'b1,18'h00003},
      {1'b0,1'b0,1'b1,1'b0,3'b101,18'h00000, 4'b0000,1'b1,18'h000F0},
      {1'b0,1'b0,1'b1,1'b0,3'b110,18'h00000, 4'b0000,1'b1,18'h00021},
      {1'b0,1'b0,1'b1,1'b0,3'b111,18'h00000, 4'b0000,1'b1,18'h00077},
      {1'b0,1'b0,1'b0,1'b0,3'b010,18'h00099, 4'b0000,1'b0,18'h00000},
      {1'b0,1'b0,1'b1,1'b0,3'b011,18'h00000, 4'b0000,1'b1,18'h00000},
      {1'b0,1'b0,1'b1,1'b0,3'b100,18'h00000, 4'b0000,1'b1,18'h00003},
      {1'b0,1'b1,1'b1,1'b0,3'b000,18'h00000, 4'b0000,1'b1,18'h1A5A5},
      {1'b0,1'b1,1'b0,1'b0,3'b100,18'h00044, 4'b0000,1'b0,18'h00000},
      {1'b0,1'b0,1'b1,1'b0,3'b100,18'h00000, 4'b0000,1'b1,18'h00003},
      {1'b1,1'b0,1'b1,1'b0,3'b000,18'h00000, 4'b0000,1'b0,18'h00000}
   };

   function automatic string vec_tag(input logic [47:0] v);
      if (v[47] || v[46])        return "R1";
      if (v[43:41] == 3'b000)    return "R2";
      if (v[43:41] == 3'b001)    return "R3";
      if (v[43:42] == 2'b01)     return "R6";
      if (!v[45])                return "R4";
      return "R5";
   endfunction

   task automatic read_ofs(input logic [2:0] a, input logic [17:0] exp, input string tag);
      @(negedge clk);
      rst_in_n = 1'b1; cs_n = 1'b0; a_en_n = 1'b0; b_en_n = 1'b0;
      rd_wr = 1'b1; oe_n = 1'b0; addr = a;
      #5;
      check(tag, 32'(rd_data), 32'(exp));
   endtask

   task automatic full_reset();
      @(negedge clk);
      rst_in_n = 1'b0; cs_n = 1'b1; a_en_n = 1'b1; b_en_n = 1'b1;
      #5;
      check("R8 port_rst asserted", 32'(port_rst), 32'd1);
      @(negedge clk);
      rst_in_n = 1'b1;
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      // reset state: every offset at its default of 8 (R8)
      full_reset();
      read_ofs(3'b100, 18'd8, "R8 fwd ae default");
      read_ofs(3'b101, 18'd8, "R8 fwd af default");
      read_ofs(3'b110, 18'd8, "R8 rev ae default");
      read_ofs(3'b111, 18'd8, "R8 rev af default");

      // table walk: strobes, output enable, read word
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         rst_in_n = 1'b1; b_en_n = 1'b0;
         cs_n    = VEC[i][47];
         a_en_n  = VEC[i][46];
         rd_wr   = VEC[i][45];
         oe_n    = VEC[i][44];
         addr    = VEC[i][43:41];
         wr_data = VEC[i][40:23];
         #5;
         check({vec_tag(VEC[i]), " strobes"}, 32'({fifo_push, fifo_pop, byp_wr, byp_rd}),
               32'(VEC[i][22:19]));
         check("R7 bus_oe", 32'(bus_oe), 32'(VEC[i][18]));
         check({vec_tag(VEC[i]), " rd_data"}, 32'(rd_data), 32'(VEC[i][17:0]));
         if (fifo_push || byp_wr)
            check("R2 out_data", 32'(out_data), 32'(VEC[i][40:23]));
      end

      // R9: reset pin low during an enabled write; the write must win
      @(negedge clk);
      rst_in_n = 1'b0; cs_n = 1'b0; a_en_n = 1'b0; b_en_n = 1'b1;
      rd_wr = 1'b0; addr = 3'b101; wr_data = 18'h0002A;
      #5;
      check("R9 no reset while accessing", 32'(port_rst), 32'd0);
      read_ofs(3'b101, 18'h0002A, "R9 write taken during reset pin");
      read_ofs(3'b100, 18'h00003, "R9 neighbour held");

      // R9: only the far enable low; nothing resets
      @(negedge clk);
      rst_in_n = 1'b0; cs_n = 1'b1; a_en_n = 1'b1; b_en_n = 1'b0;
      #5;
      check("R9 far enable blocks reset", 32'(port_rst), 32'd0);
      read_ofs(3'b110, 18'h00021, "R9 rev ae held");
      read_ofs(3'b111, 18'h00077, "R9 rev af held");

      // second full reset restores all defaults
      full_reset();
      read_ofs(3'b100, 18'd8, "R8 fwd ae restored");
      read_ofs(3'b101, 18'd8, "R8 fwd af restored");
      read_ofs(3'b110, 18'd8, "R8 rev ae restored");
      read_ofs(3'b111, 18'd8, "R8 rev af restored");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule